// File: doc/BRIEF.md
# Peripheral Register Lock Bank

This block holds one sticky lock bit per peripheral. Privileged software sets a bit to freeze the configuration registers of the matching peripheral, so that they can no longer be used to leak secret data. Each lock bit drives one lock line towards its peripheral. The access gating inside each peripheral is outside this block.

Software can only move a lock bit from 0 to 1. Only two things return bits to 0: the chip-wide active-low reset and an already-authorised debug-unlock request. The per-peripheral reset lines from the reset controller enter the block, but they are kept apart from the lock storage on purpose. Resetting one peripheral therefore cannot release the locks that protect all the others.

The whole bank sits in one 32-bit register. Bits 15:0 are the lock bits and bits 31:16 are reserved.

Top module: `periphLockBank`

## Requirements
- R1: While `rstGlobalN` is low, every lock bit is 0 and `busRdData` reads 0. The clear happens at once, without waiting for a clock edge.
- R2: When `busWrEn` is high, each bit i of `busWrData[15:0]` that is 1 sets lock bit i. `lockOut[i]` shows the new value from the first rising clock edge after the write.
- R3: A written 0 never clears a lock bit that is already 1. Lock bits change only from 0 to 1 through writes.
- R4: When `dbgUnlock` is high at a rising edge, all lock bits are 0 after that edge.
- R5: When `busWrEn` and `dbgUnlock` are high in the same cycle, the unlock wins and all lock bits are 0 after the edge.
- R6: No value on `periphRst`, alone or together with a write, clears any lock bit.
- R7: `busRdData[15:0]` always equals the current lock bits, and `busRdData[31:16]` always reads 0.
- R8: Bits 31:16 of a write are ignored. They never change any lock bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstGlobalN | input | 1 | Chip-wide asynchronous active-low reset; clears all locks |
| dbgUnlock | input | 1 | Authorised debug unlock; clears all locks at the next edge |
| periphRst | input | 16 | Per-peripheral reset requests; have no effect on the bank |
| busWrEn | input | 1 | Register write strobe |
| busWrData | input | 32 | Write data; bits 15:0 set locks, bits 31:16 reserved |
| busRdData | output | 32 | Read data: lock bits in 15:0, zero in 31:16 |
| lockOut | output | 16 | One registered lock line per peripheral |

## Verification
The assertions check the following on every cycle:
- A set bit stays set unless an unlock is applied.
- An unlock leaves the bank empty one edge later.
- Bits that are written take effect on the next edge.
- Peripheral resets and writes to reserved bits leave the lock lines steady.

Some behaviour only the bench scenarios can show. These are the exact accumulated lock patterns over a sequence of writes, the same-cycle priority of unlock over a write, and the immediate clear when the global reset is asserted in the middle of operation.

// File: rtl/lock_bank_pkg.sv
package lock_bank_pkg;
  // Strobes from control to the lock storage
  typedef struct packed {
    logic clearAll;  // drop every lock bit at the next edge
    logic setEn;     // OR the write mask into the lock bits
  } lockStrobeT;
endpackage

// File: rtl/lockBankCtrl.sv
module lockBankCtrl
  import lock_bank_pkg::*;
#(
  parameter int NUM_LOCKS = 16,
  parameter int REG_W     = 32
) (
  input  logic                 clk,
  input  logic                 rstGlobalN,
  input  logic                 dbgUnlock,
  input  logic                 busWrEn,
  input  logic [REG_W-1:0]     busWrData,
  output lockStrobeT           strobe,
  output logic [NUM_LOCKS-1:0] setMask
);
  localparam int RSV_W = REG_W - NUM_LOCKS;

  logic [RSV_W-1:0] rsvBits;

  // Only the lock field of the write word reaches the storage
  assign setMask = busWrData[NUM_LOCKS-1:0];
  assign rsvBits = busWrData[REG_W-1:NUM_LOCKS];

  // Unlock has priority over a write in the same cycle (R5)
  always_comb begin
    strobe.clearAll = dbgUnlock;
    strobe.setEn    = busWrEn && !dbgUnlock;
  end

  // R5: an unlock cycle never also produces a set strobe
  a_r5_unlock_wins: assert property (@(posedge clk) disable iff (!rstGlobalN)
    dbgUnlock |-> !strobe.setEn);

  // R8: reserved write bits are not forwarded into the mask
  a_r8_reserved_masked: assert property (@(posedge clk) disable iff (!rstGlobalN)
    (busWrEn && rsvBits != '0 && busWrData[NUM_LOCKS-1:0] == '0) |-> (setMask == '0));
endmodule

// File: rtl/lockBankRegs.sv
module lockBankRegs
  import lock_bank_pkg::*;
#(
  parameter int NUM_LOCKS = 16
) (
  input  logic                 clk,
  input  logic                 rstGlobalN,
  input  lockStrobeT           strobe,
  input  logic [NUM_LOCKS-1:0] setMask,
  output logic [NUM_LOCKS-1:0] lockQ
);
  // One storage cell per peripheral. Only the global reset and the
  // unlock strobe can clear a cell; no other reset is wired in (R6).
  for (genvar i = 0; i < NUM_LOCKS; i++) begin : g_cell
    always_ff @(posedge clk or negedge rstGlobalN) begin
      if (!rstGlobalN)
        lockQ[i] <= 1'b0;
      else if (strobe.clearAll)
        lockQ[i] <= 1'b0;
      else if (strobe.setEn && setMask[i])
        lockQ[i] <= 1'b1;
    end
  end

  // R3: without an unlock, set bits remain set
  a_r3_sticky: assert property (@(posedge clk) disable iff (!rstGlobalN)
    !strobe.clearAll |=> ((lockQ & $past(lockQ)) == $past(lockQ)));

  // R4: unlock empties the bank one edge later
  a_r4_unlock_clears: assert property (@(posedge clk) disable iff (!rstGlobalN)
    strobe.clearAll |=> (lockQ == '0));

  // R2: written ones appear on the next edge
  a_r2_set_next: assert property (@(posedge clk) disable iff (!rstGlobalN)
    strobe.setEn |=> ((lockQ & $past(setMask)) == $past(setMask)));
endmodule

// File: rtl/periphLockBank.sv
module periphLockBank
  import lock_bank_pkg::*;
#(
  parameter int NUM_LOCKS = 16,
  parameter int REG_W     = 32
) (
  input  logic                 clk,
  input  logic                 rstGlobalN,
  input  logic                 dbgUnlock,
  input  logic [NUM_LOCKS-1:0] periphRst,
  input  logic                 busWrEn,
  input  logic [REG_W-1:0]     busWrData,
  output logic [REG_W-1:0]     busRdData,
  output logic [NUM_LOCKS-1:0] lockOut
);
  localparam int RSV_W = REG_W - NUM_LOCKS;

  lockStrobeT           strobe;
  logic [NUM_LOCKS-1:0] setMask;
  logic [NUM_LOCKS-1:0] lockQ;

  lockBankCtrl #(.NUM_LOCKS(NUM_LOCKS), .REG_W(REG_W)) uCtrl (
    .clk        (clk),
    .rstGlobalN (rstGlobalN),
    .dbgUnlock  (dbgUnlock),
    .busWrEn    (busWrEn),
    .busWrData  (busWrData),
    .strobe     (strobe),
    .setMask    (setMask)
  );

  lockBankRegs #(.NUM_LOCKS(NUM_LOCKS)) uRegs (
    .clk        (clk),
    .rstGlobalN (rstGlobalN),
    .strobe     (strobe),
    .setMask    (setMask),
    .lockQ      (lockQ)
  );

  assign lockOut   = lockQ;
  assign busRdData = {{RSV_W{1'b0}}, lockQ};

  // R6: peripheral resets with no write or unlock leave the locks steady
  a_r6_periph_isolated: assert property (@(posedge clk) disable iff (!rstGlobalN)
    (periphRst != '0 && !busWrEn && !dbgUnlock) |=> $stable(lockOut));

  // R8: a write that touches only reserved bits changes nothing
  a_r8_reserved_noop: assert property (@(posedge clk) disable iff (!rstGlobalN)
    (busWrEn && !dbgUnlock && busWrData[NUM_LOCKS-1:0] == '0) |=> $stable(lockOut));

  // R7: the read word mirrors the lock lines
  a_r7_read_mirror: assert property (@(posedge clk) disable iff (!rstGlobalN)
    busRdData[NUM_LOCKS-1:0] == lockOut);
endmodule

// File: tb/periphLockBank_test.sv
module periphLockBank_test;
  logic        clk = 1'b0;
  logic        rstGlobalN = 1'b0;
  logic        dbgUnlock = 1'b0;
  logic [15:0] periphRst = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [15:0] lockOut;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  periphLockBank uut (
    .clk(clk), .rstGlobalN(rstGlobalN), .dbgUnlock(dbgUnlock),
    .periphRst(periphRst), .busWrEn(busWrEn), .busWrData(busWrData),
    .busRdData(busRdData), .lockOut(lockOut)
  );

  // {wrEn, unlock, periphRst, wrData, expected locks after edge}
  typedef struct packed {
    logic        wr;
    logic        unl;
    logic [15:0] prst;
    logic [31:0] data;
    logic [15:0] exp;
  } vecT;

  localparam int NV = 12;
  localparam vecT tbl [NV] = '{
    '{1'b1, 1'b0, 16'h0000, 32'h0000_0003, 16'h0003}, // R2 set
    '{1'b1, 1'b0, 16'h0000, 32'h0000_0000, 16'h0003}, // R3 zero ignored
    '{1'b1, 1'b0, 16'h0000, 32'h0000_8010, 16'h8013}, // R2 accumulate
    '{1'b1, 1'b0, 16'h0000, 32'hFFFF_0000, 16'h8013}, // R8 reserved
    '{1'b0, 1'b0, 16'hFFFF, 32'h0000_0000, 16'h8013}, // R6 all resets
    '{1'b1, 1'b0, 16'h0004, 32'h0000_0100, 16'h8113}, // R6 with write
    '{1'b0, 1'b1, 16'h0000, 32'h0000_0000, 16'h0000}, // R4 unlock
    '{1'b1, 1'b0, 16'h0000, 32'h0000_00F0, 16'h00F0}, // R2 after unlock
    '{1'b1, 1'b1, 16'h0000, 32'h0000_0F00, 16'h0000}, // R5 unlock wins
    '{1'b1, 1'b0, 16'h0000, 32'hFFFF_FFFF, 16'hFFFF}, // R2 all
    '{1'b1, 1'b0, 16'hFFFF, 32'h0000_0000, 16'hFFFF}, // R3 R6
    '{1'b0, 1'b1, 16'hFFFF, 32'h0000_0000, 16'h0000}  // R4 with resets
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #200000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: state while reset is held
    repeat (3) @(negedge clk);
    check("R1 reset lockOut", {16'h0, lockOut}, 32'h0);
    check("R1 reset read", busRdData, 32'h0);
    rstGlobalN = 1'b1;
    @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      busWrEn   = tbl[k].wr;
      dbgUnlock = tbl[k].unl;
      periphRst = tbl[k].prst;
      busWrData = tbl[k].data;
      @(negedge clk);
      check($sformatf("R2/R3/R4/R5/R6/R8 vec%0d lockOut", k), {16'h0, lockOut}, {16'h0, tbl[k].exp});
      check($sformatf("R7 vec%0d read", k), busRdData, {16'h0, tbl[k].exp});
    end
    busWrEn = 1'b0; dbgUnlock = 1'b0; periphRst = '0; busWrData = '0;

    // R6: many cycles of toggling peripheral resets
    busWrEn = 1'b1; busWrData = 32'h0000_A5A5;
    @(negedge clk);
    busWrEn = 1'b0;
    for (int k = 0; k < 16; k++) begin
      periphRst = 16'h1 << k;
      @(negedge clk);
    end
    periphRst = '0;
    @(negedge clk);
    check("R6 resets sweep", {16'h0, lockOut}, 32'h0000_A5A5);

    // R1: asynchronous clear mid-operation
    #1 rstGlobalN = 1'b0;
    #0.5;
    check("R1 async clear", {16'h0, lockOut}, 32'h0);
    @(negedge clk);
    rstGlobalN = 1'b1;
    @(negedge clk);
    check("R1 after release", busRdData, 32'h0);

    // R3: writes of 0 over many cycles keep a single bit
    busWrEn = 1'b1; busWrData = 32'h0000_0001;
    @(negedge clk);
    busWrData = 32'h0000_0000;
    repeat (4) @(negedge clk);
    busWrEn = 1'b0;
    check("R3 hold bit0", {16'h0, lockOut}, 32'h0000_0001);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule